// File: doc/BRIEF.md
# Flash Write Qualification and Protection Gate

This block sits between the asynchronous bus control pins of a NOR-style flash memory and its internal command state machine. It samples chip enable, write enable and output enable into the block clock domain and filters out short low pulses. A host bus cycle is passed on as a write only when it is fully qualified. The command machine then receives a single-clock write strobe together with the address and data captured during that cycle.

Two lockout conditions apply. While the digital supply-low flag is set, or just after reset, no write is accepted and the command machine is told to return to read mode. A write cycle that was already in progress when either condition clears is also discarded. For program and erase data cycles, the block also checks the addressed sector group against its stored lock bit. The active-low write-protect input additionally refuses the boundary sector group. A refused request raises a protection-violation flag instead of the strobe.

Top module: `flash_wr_gate`

## Requirements
- R1: A qualified write cycle that ends with write enable rising produces exactly one `wr_strobe` pulse of one clock, within four clocks of the rising edge. While the strobe is high, `wr_addr` and `wr_data` hold the values present on `addr_in` and `data_in` during the cycle.
- R2: A write cycle is qualified only while `ce_n` and `we_n` are low and `oe_n` is high. Any one of `oe_n` low, `ce_n` high or `we_n` high prevents any strobe.
- R3: A low level on a control pin counts only after it has been sampled low on GLITCH_CYCLES (default 3) consecutive clocks. A write pulse of fewer samples produces neither a strobe nor a violation.
- R4: While `supply_low` is high, neither `wr_strobe` nor `protect_violation` is raised, and `force_read` is high from the following clock. A write cycle that is still open when `supply_low` clears is discarded.
- R5: During reset `force_read` is high and both output flags are low. A write cycle held open across the release of reset is discarded when it ends. A later complete cycle is accepted.
- R6: While `wprot_n` is low, a program/erase request (`pe_req` high at the end of the cycle) to the boundary sector group raises `protect_violation` for one clock instead of `wr_strobe`. The boundary group is group 0 by default (BOOT_AT_TOP = 0); the group index is the top log2(NUM_GROUPS) bits of the address. Writes without `pe_req` and writes to other groups are not refused by `wprot_n`.
- R7: While `wprot_n` is high, the boundary group is refused only if its bit in `grp_lock` is set. An undriven `wprot_n` must be tied high by the integrator and then behaves this way.
- R8: For every sector group, a program/erase request is refused whenever that group's `grp_lock` bit (bit index = group index) is set, whatever the level of `wprot_n`. `wr_strobe` and `protect_violation` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, released at power-up completion |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| we_n | input | 1 | Asynchronous write enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wprot_n | input | 1 | Asynchronous write protect for the boundary group, active low |
| supply_low | input | 1 | Synchronous flag from the supply comparator, high when supply is too low |
| addr_in | input | ADDR_W | Bus address |
| data_in | input | DATA_W | Bus data |
| pe_req | input | 1 | From the command machine: the next write is a program/erase data cycle |
| grp_lock | input | NUM_GROUPS | Stored per-group lock bits |
| wr_strobe | output | 1 | One-clock qualified write strobe |
| wr_addr | output | ADDR_W | Address captured for the strobed write |
| wr_data | output | DATA_W | Data captured for the strobed write |
| protect_violation | output | 1 | One-clock flag for a refused program/erase request |
| force_read | output | 1 | Holds the command machine in read mode |

## Verification
The main function is tried with each control-pin combination that should or should not form a write. These patterns separate the three blocking conditions from one another. The length of the write-enable pulse is stepped across the filter threshold, which pins down the exact sample count. Program/erase requests are applied to the boundary group, an inner group and the far end group under each write-protect level and lock setting. This shows whether the protect input reaches only the boundary group and whether the lock bits apply everywhere. Cycles opened across reset release and across the end of a supply-low period check that a partly seen cycle is dropped.

// File: rtl/flash_wr_gate_pkg.sv
package flash_wr_gate_pkg;

    // Filtered, synchronized levels of the bus control pins (active low).
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ctl_lvl_t;

    localparam int unsigned CTL_PINS = 3;

endpackage

// File: rtl/fwg_pin_filter.sv
module fwg_pin_filter #(
    parameter int unsigned GLITCH_CYCLES = 3,
    parameter bit          USE_FILTER    = 1'b1,
    parameter bit          RST_VAL       = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    localparam int unsigned CNT_W = (GLITCH_CYCLES < 2) ? 1 : $clog2(GLITCH_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GLITCH_CYCLES - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = pin_i;
        r_d.s2 = r_q.s1;
        if (USE_FILTER) begin
            // high is taken at once, low only after a run of low samples
            if (r_q.s2) begin
                r_d.lvl = 1'b1;
                r_d.cnt = '0;
            end else if (r_q.lvl) begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.lvl = 1'b0;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end else begin
            r_d.lvl = r_q.s2;
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1  <= RST_VAL;
            r_q.s2  <= RST_VAL;
            r_q.lvl <= RST_VAL;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign level_o = r_q.lvl;

endmodule

// File: rtl/fwg_wr_qual.sv
module fwg_wr_qual
    import flash_wr_gate_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_lvl_t          ctl_i,
    input  logic              supply_low_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              done_o,
    output logic              armed_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              active;
        logic              armed;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } qual_t;

    qual_t r_d, r_q;
    logic  active;
    logic  done;

    always_comb begin
        active = !ctl_i.ce_n && !ctl_i.we_n && ctl_i.oe_n;
        // a cycle closes on write enable rising; only armed cycles count
        done   = r_q.active && !active && ctl_i.we_n && r_q.armed && !supply_low_i;

        r_d        = r_q;
        r_d.active = active && !supply_low_i;
        if (supply_low_i) begin
            r_d.armed = 1'b0;
        end else if (!active) begin
            r_d.armed = 1'b1;
        end
        if (active) begin
            r_d.addr = addr_i;
            r_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.active <= 1'b1;
            r_q.armed  <= 1'b0;
            r_q.addr   <= '0;
            r_q.data   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o  = done;
    assign armed_o = r_q.armed;
    assign addr_o  = r_q.addr;
    assign data_o  = r_q.data;

endmodule

// File: rtl/fwg_grp_prot.sv
module fwg_grp_prot #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_GROUPS  = 8,
    parameter bit          BOOT_AT_TOP = 1'b0
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [NUM_GROUPS-1:0] lock_i,
    input  logic                  wprot_lvl_i,
    output logic                  refused_o
);

    localparam int unsigned GRP_W = (NUM_GROUPS < 2) ? 1 : $clog2(NUM_GROUPS);

    logic [GRP_W-1:0] grp;
    logic [GRP_W-1:0] boundary;

    assign grp = addr_i[ADDR_W-1 -: GRP_W];

    generate
        if (BOOT_AT_TOP) begin : g_top
            assign boundary = GRP_W'(NUM_GROUPS - 1);
        end else begin : g_bottom
            assign boundary = '0;
        end
    endgenerate

    always_comb begin
        refused_o = lock_i[grp];
        if (grp == boundary && !wprot_lvl_i) begin
            refused_o = 1'b1;
        end
    end

endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate
    import flash_wr_gate_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned NUM_GROUPS    = 8,
    parameter int unsigned GLITCH_CYCLES = 3,
    parameter bit          BOOT_AT_TOP   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic                  wprot_n,
    input  logic                  supply_low,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic [DATA_W-1:0]     data_in,
    input  logic                  pe_req,
    input  logic [NUM_GROUPS-1:0] grp_lock,
    output logic                  wr_strobe,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  protect_violation,
    output logic                  force_read
);

    localparam logic [CTL_PINS-1:0] PIN_RST = 3'b001; // ce, we held asserted; oe idle

    ctl_lvl_t            pins_raw;
    ctl_lvl_t            ctl_lvl;
    logic [CTL_PINS-1:0] pins_vec;
    logic [CTL_PINS-1:0] lvl_vec;
    logic                wprot_lvl;
    logic                done;
    logic                armed_w;
    logic                refused;
    logic [ADDR_W-1:0]   cap_addr;
    logic [DATA_W-1:0]   cap_data;

    assign pins_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};
    assign pins_vec = pins_raw;
    assign ctl_lvl  = lvl_vec;

    generate
        for (genvar i = 0; i < CTL_PINS; i++) begin : g_ctl
            fwg_pin_filter #(
                .GLITCH_CYCLES (GLITCH_CYCLES),
                .USE_FILTER    (1'b1),
                .RST_VAL       (PIN_RST[i])
            ) u_flt (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (pins_vec[i]),
                .level_o (lvl_vec[i])
            );
        end
    endgenerate

    fwg_pin_filter #(
        .GLITCH_CYCLES (GLITCH_CYCLES),
        .USE_FILTER    (1'b0),
        .RST_VAL       (1'b1)
    ) u_wp_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (wprot_n),
        .level_o (wprot_lvl)
    );

    fwg_wr_qual #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_i        (ctl_lvl),
        .supply_low_i (supply_low),
        .addr_i       (addr_in),
        .data_i       (data_in),
        .done_o       (done),
        .armed_o      (armed_w),
        .addr_o       (cap_addr),
        .data_o       (cap_data)
    );

    fwg_grp_prot #(
        .ADDR_W      (ADDR_W),
        .NUM_GROUPS  (NUM_GROUPS),
        .BOOT_AT_TOP (BOOT_AT_TOP)
    ) u_prot (
        .addr_i      (cap_addr),
        .lock_i      (grp_lock),
        .wprot_lvl_i (wprot_lvl),
        .refused_o   (refused)
    );

    typedef struct packed {
        logic              strobe;
        logic              viol;
        logic              frd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d        = o_q;
        o_d.strobe = done && !(pe_req && refused);
        o_d.viol   = done && pe_req && refused;
        o_d.frd    = supply_low;
        if (done) begin
            o_d.addr = cap_addr;
            o_d.data = cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.strobe <= 1'b0;
            o_q.viol   <= 1'b0;
            o_q.frd    <= 1'b1;
            o_q.addr   <= '0;
            o_q.data   <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign wr_strobe         = o_q.strobe;
    assign protect_violation = o_q.viol;
    assign force_read        = o_q.frd;
    assign wr_addr           = o_q.addr;
    assign wr_data           = o_q.data;

endmodule

// File: rtl/flash_wr_gate_chk.sv
module flash_wr_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_low,
    input logic pe_req,
    input logic armed,
    input logic wr_strobe,
    input logic protect_violation,
    input logic force_read
);

    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe); // R1

    AST_VIOL_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        protect_violation |=> !protect_violation); // R6

    AST_LOWSUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (!wr_strobe && !protect_violation)); // R4

    AST_LOWSUP_READ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> force_read); // R4

    AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (!wr_strobe && !protect_violation)); // R5

    AST_VIOL_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
        protect_violation |-> $past(pe_req)); // R6

    always @(posedge clk) begin
        if (rst_n) begin
            AST_FLAGS_EXCLUSIVE: assert (!(wr_strobe && protect_violation)); // R8
        end
    end

endmodule

bind flash_wr_gate flash_wr_gate_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .supply_low        (supply_low),
    .pe_req            (pe_req),
    .armed             (armed_w),
    .wr_strobe         (wr_strobe),
    .protect_violation (protect_violation),
    .force_read        (force_read)
);

// File: tb/flash_wr_gate_bench.sv
module flash_wr_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int NG = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wprot_n = 1'b1;
    logic          supply_low = 1'b0, pe_req = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [NG-1:0] grp_lock = '0;
    logic          wr_strobe, protect_violation, force_read;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0, n_err = 0;
    int n_str = 0, n_vio = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wr_gate u_flash_wr_gate (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
        .wprot_n (wprot_n), .supply_low (supply_low), .addr_in (addr_in),
        .data_in (data_in), .pe_req (pe_req), .grp_lock (grp_lock),
        .wr_strobe (wr_strobe), .wr_addr (wr_addr), .wr_data (wr_data),
        .protect_violation (protect_violation), .force_read (force_read)
    );

    // output monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe) begin
                n_str++;
                last_addr = wr_addr;
                last_data = wr_data;
            end
            if (protect_violation) n_vio++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive the selected pins low for cyc clocks, then release all
    task automatic bus_cycle(input logic ce, input logic we, input logic oe,
                             input int cyc, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr_in = a; data_in = d;
        ce_n = !ce; we_n = !we; oe_n = !oe;
        repeat (cyc) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    typedef struct packed {
        logic       ce, we, oe;
        logic [3:0] cyc;
        logic       pe, wp;
        logic [7:0] lock;
        logic [11:0] addr;
        logic [7:0] data;
        logic       es, ev;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1,1,0, 5, 0,1, 8'h00, 12'h010, 8'h5A, 1,0},  // R1 plain write
        '{1,1,1, 5, 0,1, 8'h00, 12'h010, 8'h11, 0,0},  // R2 oe low blocks
        '{0,1,0, 5, 0,1, 8'h00, 12'h010, 8'h22, 0,0},  // R2 ce high blocks
        '{1,0,0, 5, 0,1, 8'h00, 12'h010, 8'h33, 0,0},  // R2 we high blocks
        '{1,1,0, 2, 0,1, 8'h00, 12'h010, 8'h44, 0,0},  // R3 short pulse
        '{1,1,0, 3, 0,1, 8'h00, 12'h123, 8'h55, 1,0},  // R3 exact threshold
        '{1,1,0, 5, 1,0, 8'h00, 12'h010, 8'h66, 0,1},  // R6 boundary protected
        '{1,1,0, 5, 1,1, 8'h00, 12'h010, 8'h77, 1,0},  // R7 boundary unlocked
        '{1,1,0, 5, 1,1, 8'h01, 12'h010, 8'h88, 0,1},  // R7 boundary locked
        '{1,1,0, 5, 1,0, 8'h00, 12'h6A5, 8'h99, 1,0},  // R6 inner group free
        '{1,1,0, 5, 1,0, 8'h08, 12'h6A5, 8'hAA, 0,1},  // R8 inner group locked
        '{1,1,0, 5, 0,0, 8'h00, 12'h010, 8'hBB, 1,0},  // R6 non-PE write passes
        '{1,1,0, 5, 1,0, 8'h00, 12'hE00, 8'hCC, 1,0}   // R6 far end group free
    };

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int s0, v0;
        // reset state
        repeat (3) @(negedge clk);
        chk("R5 reset force_read", force_read, 1);
        chk("R5 reset strobe", wr_strobe, 0);
        chk("R5 reset violation", protect_violation, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 force_read released", force_read, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pe_req = TBL[i].pe; wprot_n = TBL[i].wp; grp_lock = TBL[i].lock;
            repeat (4) @(negedge clk);
            s0 = n_str; v0 = n_vio;
            bus_cycle(TBL[i].ce, TBL[i].we, TBL[i].oe, int'(TBL[i].cyc), TBL[i].addr, TBL[i].data);
            chk($sformatf("R1/R2/R3/R6/R7/R8 vec%0d strobes", i), n_str - s0, int'(TBL[i].es));
            chk($sformatf("R6/R7/R8 vec%0d violations", i), n_vio - v0, int'(TBL[i].ev));
            if (TBL[i].es) begin
                chk($sformatf("R1 vec%0d addr", i), int'(last_addr), int'(TBL[i].addr));
                chk($sformatf("R1 vec%0d data", i), int'(last_data), int'(TBL[i].data));
            end
        end
        pe_req = 1'b0; wprot_n = 1'b1; grp_lock = '0;

        // R4 supply low: lockout and read mode
        @(negedge clk); supply_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 force_read during low supply", force_read, 1);
        s0 = n_str;
        bus_cycle(1, 1, 0, 5, 12'h321, 8'h3C);
        chk("R4 write ignored during low supply", n_str - s0, 0);
        // cycle opened during low supply, closed after it clears
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
        repeat (6) @(negedge clk);
        supply_low = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 force_read cleared", force_read, 0);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R4 straddling cycle discarded", n_str - s0, 0);
        bus_cycle(1, 1, 0, 5, 12'h321, 8'h3C);
        chk("R4 write accepted after recovery", n_str - s0, 1);
        chk("R4 recovered data", int'(last_data), 8'h3C);

        // R5 power-up inhibit: cycle held through reset release
        @(negedge clk); rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        s0 = n_str; v0 = n_vio;
        ce_n = 1'b1; we_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 power-up cycle rejected", n_str - s0, 0);
        chk("R5 power-up no violation", n_vio - v0, 0);
        bus_cycle(1, 1, 0, 5, 12'h456, 8'hE7);
        chk("R5 later write accepted", n_str - s0, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule